// File: doc/BRIEF.md
# Serial NOR Flash Command and Write-Protect Unit

This block sits on the device side of a serial NOR flash. It takes the command stream one byte at a time, after a bit-level shifter has assembled each byte, while chip select is low. It decodes each opcode, keeps the status register and answers identification and status reads. It also decides whether a program or erase may proceed. The storage array is not part of the block. Reads look up the array through a combinational data input. Program bytes, sector erases and bulk erases go out as single-cycle request pulses that carry the address on a shared address port.

The status register holds five things: a write-enable latch, a four-bit block-protect count, a top/bottom select and a status-write-disable bit. The status-write-disable bit works together with the active-low write-protect pin. The protected region is a power-of-two number of 64 KB sectors, taken from the top or the bottom of the array. A program or erase that targets a protected sector produces no request. Commands that carry an address take three address bytes, or four once the device has entered 4-byte addressing mode.

Top module: `fnor_wp_unit`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch (status bit 1) and 0x04 clears it. After opcode 0x05, tx_byte_o presents the status byte, and it keeps presenting it for every further byte of that select period. Status bit 0 always reads 0. After reset the status byte is 0x00.
- R2: After opcode 0x9F, tx_byte_o presents 0x20. Each further byte advances it to 0xBA, then 0x19, then 0x00, where it stays.
- R3: Opcode 0x01 followed by one data byte writes data bits 7:2 into status bits 7:2, but only if the write-enable latch is set. The latch is cleared in either case. The next byte in the same select period is decoded as a new opcode.
- R4: A status write is ignored when wp_ni is 0 and status bit 7 is 1. In every other combination it is accepted.
- R5: Let n be the value formed by status bits {6,4,3,2}, with bit 6 as the most significant. The number of protected 64 KB sectors is 0 when n is 0, and otherwise 2^(n-1), capped at the sector count of the array (512 by default).
- R6: When status bit 5 is 0, the protected sectors are the highest-numbered ones. When it is 1, the protected sectors are those counted up from sector 0.
- R7: Page program is opcode 0x02, followed by the address, followed by data bytes. The cycle after each data byte, mem_prog_o pulses with mem_addr_o and mem_wdata_o. The address then increments within its 256-byte page and wraps at the page end. The pulse is suppressed when the addressed sector is protected. Raising chip select clears the write-enable latch.
- R8: Sector erase is opcode 0xD8 followed by the address. The cycle after the last address byte, mem_sect_erase_o pulses with mem_addr_o, unless the addressed sector is protected. That same cycle clears the write-enable latch.
- R9: Bulk erase is opcode 0xC7. In the next cycle, mem_bulk_erase_o pulses only if the protect count n is 0. That cycle clears the write-enable latch.
- R10: If the write-enable latch is clear, program, sector erase and bulk erase raise no request.
- R11: Read is opcode 0x03 followed by the address. After the last address byte, tx_byte_o follows mem_rdata_i, and mem_addr_o increments by one for each further byte.
- R12: Opcode 0xB7 sets addr4_o. While addr4_o is set, addressed commands take four address bytes, most significant first. Otherwise they take three.
- R13: Opcode 0x66 followed directly by opcode 0x99 clears the status register and addr4_o. A 0x99 that is not directly preceded by 0x66 has no effect.
- R14: Raising chip select abandons any command in progress, so the next byte is an opcode. At most one memory request is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rx_vld_i | input | 1 | A received byte is present this cycle |
| rx_byte_i | input | 8 | Received byte |
| wp_ni | input | 1 | Write-protect pin, active low |
| mem_rdata_i | input | 8 | Array data at mem_addr_o |
| tx_byte_o | output | 8 | Byte to return to the host |
| mem_addr_o | output | ADDR_W | Array address for read, program and erase |
| mem_wdata_o | output | 8 | Program data |
| mem_prog_o | output | 1 | Program one byte |
| mem_sect_erase_o | output | 1 | Erase the 64 KB sector at mem_addr_o |
| mem_bulk_erase_o | output | 1 | Erase the whole array |
| addr4_o | output | 1 | 4-byte addressing mode active |

## Verification
Two things can happen in the same cycle: the final program pulse of a page program, and the chip-select rise that ends the command and clears the write-enable latch. The bench raises chip select in exactly the cycle where the pulse from the last data byte is present. It then checks that the pulse still appears, because the latch is cleared only at the end of that cycle, and that a following status read shows the latch cleared. The same check applies to a sector erase, whose request cycle also clears the latch. In addition, the table of protection vectors checks each erase decision against both edges of the protected range.

// File: rtl/fnor_pkg.sv
package fnor_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_RDID   = 8'h9F;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PP     = 8'h02;
  localparam logic [7:0] OP_SE     = 8'hD8;
  localparam logic [7:0] OP_BE     = 8'hC7;
  localparam logic [7:0] OP_EN4B   = 8'hB7;
  localparam logic [7:0] OP_RST_EN = 8'h66;
  localparam logic [7:0] OP_RST    = 8'h99;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_PROG, ST_READ, ST_RDSR, ST_RDID, ST_WRSR, ST_SINK
  } dec_st_e;
endpackage

// File: rtl/fnor_status_reg.sv
module fnor_status_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wp_ni,
  input  logic       set_wel_i,
  input  logic       clr_wel_i,
  input  logic       sr_wr_i,
  input  logic [5:0] sr_wdata_i,
  input  logic       soft_rst_i,
  output logic [7:0] sr_o
);
  logic [7:1] sr_q;
  logic       locked;

  assign locked = ~wp_ni & sr_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (soft_rst_i) begin
      sr_q <= '0;
    end else if (sr_wr_i) begin
      if (sr_q[1] && !locked) sr_q[7:2] <= sr_wdata_i;
      sr_q[1] <= 1'b0;
    end else if (set_wel_i) begin
      sr_q[1] <= 1'b1;
    end else if (clr_wel_i) begin
      sr_q[1] <= 1'b0;
    end
  end

  assign sr_o = {sr_q, 1'b0};
endmodule

// File: rtl/fnor_prot_map.sv
module fnor_prot_map #(
  parameter int SECT_W = 9
) (
  input  logic [SECT_W-1:0] sect_i,
  input  logic [3:0]        bp_i,
  input  logic              tb_i,
  output logic              hit_o,
  output logic              any_o
);
  localparam int NSECT = 1 << SECT_W;
  localparam int CW    = SECT_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] sect_x;

  always_comb begin
    if (bp_i == 4'd0)                cnt = '0;
    else if (32'(bp_i) > SECT_W)     cnt = CW'(NSECT);
    else                             cnt = CW'(1) << (bp_i - 4'd1);
  end

  assign sect_x = {1'b0, sect_i};
  assign hit_o  = tb_i ? (sect_x < cnt) : (sect_x >= (CW'(NSECT) - cnt));
  assign any_o  = (bp_i != 4'd0);
endmodule

// File: rtl/fnor_cmd_dec.sv
module fnor_cmd_dec
  import fnor_pkg::*;
#(
  parameter int ADDR_W    = 25,
  parameter int PAGE_LOG2 = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rx_vld_i,
  input  logic [7:0]        rx_byte_i,
  output dec_st_e           st_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        id_idx_o,
  output logic              addr4_o,
  output logic              set_wel_o,
  output logic              clr_wel_o,
  output logic              sr_wr_o,
  output logic [5:0]        sr_wdata_o,
  output logic              soft_rst_o,
  output logic              prog_pend_o,
  output logic              sect_pend_o,
  output logic              bulk_pend_o,
  output logic [7:0]        wdata_o
);
  dec_st_e           st_q;
  logic [7:0]        cmd_q;
  logic [1:0]        addr_cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        id_idx_q;
  logic              addr4_q, rst_arm_q;
  logic              prog_pend_q, sect_pend_q, bulk_pend_q;
  logic [7:0]        wdata_q;
  logic              take, at_op, addr_last;

  assign take      = rx_vld_i & ~cs_ni;
  assign at_op     = take & (st_q == ST_OP);
  assign addr_last = (addr_cnt_q == (addr4_q ? 2'd3 : 2'd2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_OP;
      cmd_q       <= '0;
      addr_cnt_q  <= '0;
      addr_q      <= '0;
      id_idx_q    <= '0;
      addr4_q     <= 1'b0;
      rst_arm_q   <= 1'b0;
      prog_pend_q <= 1'b0;
      sect_pend_q <= 1'b0;
      bulk_pend_q <= 1'b0;
      wdata_q     <= '0;
    end else begin
      prog_pend_q <= 1'b0;
      sect_pend_q <= 1'b0;
      bulk_pend_q <= 1'b0;
      // advance within the page once the previous byte has been issued
      if (prog_pend_q)
        addr_q[PAGE_LOG2-1:0] <= addr_q[PAGE_LOG2-1:0] + PAGE_LOG2'(1);
      if (cs_ni) begin
        st_q <= ST_OP;
      end else if (rx_vld_i) begin
        unique case (st_q)
          ST_OP: begin
            rst_arm_q <= (rx_byte_i == OP_RST_EN);
            case (rx_byte_i)
              OP_READ, OP_PP, OP_SE: begin
                st_q       <= ST_ADDR;
                cmd_q      <= rx_byte_i;
                addr_q     <= '0;
                addr_cnt_q <= '0;
              end
              OP_RDSR: st_q <= ST_RDSR;
              OP_RDID: begin
                st_q     <= ST_RDID;
                id_idx_q <= '0;
              end
              OP_WRSR: st_q <= ST_WRSR;
              OP_BE:   bulk_pend_q <= 1'b1;
              OP_EN4B: addr4_q <= 1'b1;
              OP_RST:  if (rst_arm_q) addr4_q <= 1'b0;
              OP_WREN, OP_WRDI, OP_RST_EN: ;
              default: st_q <= ST_SINK;
            endcase
          end
          ST_ADDR: begin
            addr_q     <= {addr_q[ADDR_W-9:0], rx_byte_i};
            addr_cnt_q <= addr_cnt_q + 2'd1;
            if (addr_last) begin
              if (cmd_q == OP_READ)    st_q <= ST_READ;
              else if (cmd_q == OP_PP) st_q <= ST_PROG;
              else begin
                sect_pend_q <= 1'b1;
                st_q        <= ST_OP;
              end
            end
          end
          ST_PROG: begin
            prog_pend_q <= 1'b1;
            wdata_q     <= rx_byte_i;
          end
          ST_READ: addr_q <= addr_q + ADDR_W'(1);
          ST_RDID: if (id_idx_q != 2'd3) id_idx_q <= id_idx_q + 2'd1;
          ST_WRSR: st_q <= ST_OP;
          ST_RDSR, ST_SINK: ;
          default: st_q <= ST_OP;
        endcase
      end
    end
  end

  assign set_wel_o  = at_op & (rx_byte_i == OP_WREN);
  assign clr_wel_o  = (at_op & (rx_byte_i == OP_WRDI)) | (cs_ni & (st_q == ST_PROG))
                    | sect_pend_q | bulk_pend_q;
  assign sr_wr_o    = take & (st_q == ST_WRSR);
  assign sr_wdata_o = rx_byte_i[7:2];
  assign soft_rst_o = at_op & (rx_byte_i == OP_RST) & rst_arm_q;

  assign st_o        = st_q;
  assign addr_o      = addr_q;
  assign id_idx_o    = id_idx_q;
  assign addr4_o     = addr4_q;
  assign prog_pend_o = prog_pend_q;
  assign sect_pend_o = sect_pend_q;
  assign bulk_pend_o = bulk_pend_q;
  assign wdata_o     = wdata_q;
endmodule

// File: rtl/fnor_wp_unit.sv
module fnor_wp_unit
  import fnor_pkg::*;
#(
  parameter int          ADDR_W    = 25,
  parameter int          SECT_LOG2 = 16,
  parameter int          PAGE_LOG2 = 8,
  parameter logic [23:0] DEV_ID    = 24'h20BA19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rx_vld_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              wp_ni,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        tx_byte_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_prog_o,
  output logic              mem_sect_erase_o,
  output logic              mem_bulk_erase_o,
  output logic              addr4_o
);
  localparam int SECT_W = ADDR_W - SECT_LOG2;

  dec_st_e           st_w;
  logic [ADDR_W-1:0] addr_w;
  logic [1:0]        id_idx_w;
  logic              set_wel_w, clr_wel_w, sr_wr_w, soft_rst_w;
  logic [5:0]        sr_wdata_w;
  logic              prog_pend_w, sect_pend_w, bulk_pend_w;
  logic [7:0]        wdata_w;
  logic [7:0]        sr_w;
  logic              hit_w, any_w;

  fnor_cmd_dec #(.ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2)) u_dec (
    .clk_i, .rst_ni, .cs_ni, .rx_vld_i, .rx_byte_i,
    .st_o(st_w), .addr_o(addr_w), .id_idx_o(id_idx_w), .addr4_o(addr4_o),
    .set_wel_o(set_wel_w), .clr_wel_o(clr_wel_w), .sr_wr_o(sr_wr_w),
    .sr_wdata_o(sr_wdata_w), .soft_rst_o(soft_rst_w),
    .prog_pend_o(prog_pend_w), .sect_pend_o(sect_pend_w),
    .bulk_pend_o(bulk_pend_w), .wdata_o(wdata_w)
  );

  fnor_status_reg u_sr (
    .clk_i, .rst_ni, .wp_ni,
    .set_wel_i(set_wel_w), .clr_wel_i(clr_wel_w), .sr_wr_i(sr_wr_w),
    .sr_wdata_i(sr_wdata_w), .soft_rst_i(soft_rst_w), .sr_o(sr_w)
  );

  fnor_prot_map #(.SECT_W(SECT_W)) u_prot (
    .sect_i(addr_w[ADDR_W-1:SECT_LOG2]),
    .bp_i({sr_w[6], sr_w[4:2]}),
    .tb_i(sr_w[5]),
    .hit_o(hit_w),
    .any_o(any_w)
  );

  always_comb begin
    unique case (st_w)
      ST_RDSR: tx_byte_o = sr_w;
      ST_READ: tx_byte_o = mem_rdata_i;
      ST_RDID: begin
        case (id_idx_w)
          2'd0:    tx_byte_o = DEV_ID[23:16];
          2'd1:    tx_byte_o = DEV_ID[15:8];
          2'd2:    tx_byte_o = DEV_ID[7:0];
          default: tx_byte_o = 8'h00;
        endcase
      end
      default: tx_byte_o = 8'h00;
    endcase
  end

  assign mem_addr_o       = addr_w;
  assign mem_wdata_o      = wdata_w;
  assign mem_prog_o       = prog_pend_w & sr_w[1] & ~hit_w;
  assign mem_sect_erase_o = sect_pend_w & sr_w[1] & ~hit_w;
  assign mem_bulk_erase_o = bulk_pend_w & sr_w[1] & ~any_w;
endmodule

// File: rtl/fnor_wp_chk.sv
module fnor_wp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wp_ni,
  input logic       mem_prog_i,
  input logic       mem_sect_i,
  input logic       mem_bulk_i,
  input logic [7:0] sr_i,
  input logic       set_wel_i,
  input logic       soft_rst_i,
  input logic       addr4_i
);
  p_req_wel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_prog_i || mem_sect_i || mem_bulk_i) |-> sr_i[1]);

  p_one_req_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_prog_i, mem_sect_i, mem_bulk_i}));

  p_bulk_unprot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_bulk_i |-> (sr_i[6] == 1'b0 && sr_i[4:2] == 3'd0));

  p_sr_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_ni && sr_i[7] && !soft_rst_i) |=> $stable(sr_i[7:2]));

  p_wel_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wel_i |=> sr_i[1]);

  p_soft_rst_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!addr4_i && sr_i == 8'h00));
endmodule

bind fnor_wp_unit fnor_wp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wp_ni(wp_ni),
  .mem_prog_i(mem_prog_o), .mem_sect_i(mem_sect_erase_o), .mem_bulk_i(mem_bulk_erase_o),
  .sr_i(sr_w), .set_wel_i(set_wel_w), .soft_rst_i(soft_rst_w), .addr4_i(addr4_o)
);

// File: tb/fnor_wp_unit_tb.sv
`timescale 1ns/100ps
module fnor_wp_unit_tb_top;
  localparam int ADDR_W = 25;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs_n = 1'b1;
  logic              rx_vld = 1'b0;
  logic [7:0]        rx_byte = 8'h00;
  logic              wp_n = 1'b1;
  logic [7:0]        rdata;
  logic [7:0]        tx;
  logic [ADDR_W-1:0] maddr;
  logic [7:0]        wdata;
  logic              prog, sect, bulk, a4;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign rdata = maddr[7:0] ^ 8'h5A;

  fnor_wp_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte),
    .wp_ni(wp_n), .mem_rdata_i(rdata), .tx_byte_o(tx), .mem_addr_o(maddr),
    .mem_wdata_o(wdata), .mem_prog_o(prog), .mem_sect_erase_o(sect),
    .mem_bulk_erase_o(bulk), .addr4_o(a4)
  );

  // {n[3:0], tb, sector[8:0], protected}
  localparam logic [14:0] VEC [0:13] = '{
    {4'd0,  1'b0, 9'd511, 1'b0},
    {4'd1,  1'b0, 9'd511, 1'b1},
    {4'd1,  1'b0, 9'd510, 1'b0},
    {4'd2,  1'b0, 9'd510, 1'b1},
    {4'd2,  1'b0, 9'd509, 1'b0},
    {4'd4,  1'b0, 9'd504, 1'b1},
    {4'd4,  1'b0, 9'd503, 1'b0},
    {4'd1,  1'b1, 9'd0,   1'b1},
    {4'd1,  1'b1, 9'd1,   1'b0},
    {4'd9,  1'b1, 9'd255, 1'b1},
    {4'd9,  1'b1, 9'd256, 1'b0},
    {4'd10, 1'b0, 9'd0,   1'b1},
    {4'd15, 1'b1, 9'd511, 1'b1},
    {4'd9,  1'b0, 9'd255, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cs_lo();
    @(negedge clk) cs_n = 1'b0;
  endtask

  task automatic cs_hi();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin rx_vld = 1'b1; rx_byte = b; end
    @(negedge clk) rx_vld = 1'b0;
  endtask

  task automatic rdsr(output logic [7:0] s);
    cs_lo(); send(8'h05); s = tx; cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    cs_lo(); send(8'h06); send(8'h01); send(v); cs_hi();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R1 reset tx", tx, 8'h00);
    check("R14 reset requests", {prog, sect, bulk}, 3'b000);
    check("R12 reset addr4", a4, 1'b0);
    rdsr(s); check("R1 reset status", s, 8'h00);

    // R1 latch set/clear and status streaming
    cs_lo(); send(8'h06); send(8'h05); check("R1 wel set", tx, 8'h02);
    send(8'h00); check("R1 status stream", tx, 8'h02); cs_hi();
    cs_lo(); send(8'h04); send(8'h05); check("R1 wel clear", tx, 8'h00); cs_hi();

    // R2 identification
    cs_lo(); send(8'h9F); check("R2 id byte0", tx, 8'h20);
    send(8'h00); check("R2 id byte1", tx, 8'hBA);
    send(8'h00); check("R2 id byte2", tx, 8'h19);
    send(8'h00); check("R2 id after", tx, 8'h00); cs_hi();

    // R3 status write
    cs_lo(); send(8'h01); send(8'h9C); cs_hi();
    rdsr(s); check("R3 write without wel", s, 8'h00);
    wrsr(8'hFF); rdsr(s); check("R3 write accepted", s, 8'hFC);

    // R4 lock by pin and SRWD
    wp_n = 1'b0; wrsr(8'h00); rdsr(s); check("R4 locked", s, 8'hFC);
    wp_n = 1'b1; wrsr(8'h00); rdsr(s); check("R4 pin high srwd set", s, 8'h00);
    wp_n = 1'b0; wrsr(8'h80); rdsr(s); check("R4 pin low srwd clear", s, 8'h80);
    wp_n = 1'b1; wrsr(8'h00); rdsr(s); check("R4 unlocked clear", s, 8'h00);

    // R7 page program with wrap
    cs_lo(); send(8'h06); send(8'h02); send(8'h12); send(8'h34); send(8'hFE);
    send(8'hA1);
    check("R7 prog pulse", prog, 1'b1);
    check("R7 prog addr", maddr, 25'h01234FE);
    check("R7 prog data", wdata, 8'hA1);
    send(8'hA2); check("R7 prog addr+1", maddr, 25'h01234FF);
    send(8'hA3); check("R7 page wrap", maddr, 25'h0123400);
    check("R7 wrap pulse", prog, 1'b1);
    cs_hi();
    rdsr(s); check("R7 wel cleared", s, 8'h00);

    // R10 program without latch
    cs_lo(); send(8'h02); send(8'h00); send(8'h00); send(8'h10); send(8'h55);
    check("R10 prog blocked", prog, 1'b0); cs_hi();

    // R11 read
    cs_lo(); send(8'h03); send(8'h00); send(8'h10); send(8'h20);
    check("R11 read addr", maddr, 25'h0001020);
    check("R11 read data", tx, 8'h7A);
    send(8'h00);
    check("R11 read incr", maddr, 25'h0001021);
    check("R11 read data2", tx, 8'h7B);
    cs_hi();

    // R14 abort by chip select
    cs_lo(); send(8'h03); send(8'h00); send(8'h10); cs_hi();
    cs_lo(); send(8'h06); send(8'h05); check("R14 opcode after abort", tx, 8'h02); cs_hi();
    cs_lo(); send(8'h04); cs_hi();

    // R9 bulk erase
    cs_lo(); send(8'h06); send(8'hC7); check("R9 bulk unprotected", bulk, 1'b1); cs_hi();
    rdsr(s); check("R9 wel cleared", s, 8'h00);
    cs_lo(); send(8'h06); send(8'h01); send(8'h04); send(8'h06); send(8'hC7);
    check("R9 bulk protected", bulk, 1'b0); cs_hi();
    rdsr(s); check("R9 wel cleared protected", s, 8'h04);
    wrsr(8'h00);
    cs_lo(); send(8'hC7); check("R10 bulk no wel", bulk, 1'b0); cs_hi();

    // R8 sector erase
    cs_lo(); send(8'hD8); send(8'h00); send(8'h00); send(8'h00);
    check("R10 erase no wel", sect, 1'b0); cs_hi();
    cs_lo(); send(8'h06); send(8'hD8); send(8'h01); send(8'h00); send(8'h00);
    check("R8 erase pulse", sect, 1'b1);
    check("R8 erase addr", maddr, 25'h0010000); cs_hi();
    rdsr(s); check("R8 wel cleared", s, 8'h00);

    // last program pulse in the same cycle as chip select rise
    cs_lo(); send(8'h06); send(8'h02); send(8'h00); send(8'h20); send(8'h00);
    send(8'h77);
    cs_n = 1'b1;
    #1 check("R7 pulse with cs rise", prog, 1'b1);
    @(negedge clk);
    rdsr(s); check("R7 wel cleared at cs rise", s, 8'h00);

    // R12 4-byte mode
    cs_lo(); send(8'hB7); check("R12 mode set", a4, 1'b1); cs_hi();
    cs_lo(); send(8'h03); send(8'h01); send(8'h23); send(8'h45);
    check("R12 still addressing", tx, 8'h00);
    send(8'h67);
    check("R12 4-byte addr", maddr, 25'h1234567);
    check("R11 read data 4b", tx, 8'h3D);
    cs_hi();

    // R5/R6 protection vectors
    for (int i = 0; i < 14; i++) begin
      logic [3:0] n;
      logic       tb;
      logic [8:0] sc;
      n  = VEC[i][14:11];
      tb = VEC[i][10];
      sc = VEC[i][9:1];
      cs_lo();
      send(8'h06); send(8'h01); send({1'b0, n[3], tb, n[2:0], 2'b00});
      send(8'h06); send(8'hD8);
      send({7'b0, sc[8]}); send(sc[7:0]); send(8'h00); send(8'h00);
      check(tb ? "R6 bottom range erase" : "R5 top range erase", sect, !VEC[i][0]);
      cs_hi();
    end
    wrsr(8'h00);

    // R13 reset pair
    wrsr(8'h1C);
    cs_lo(); send(8'h99); cs_hi();
    check("R13 lone reset ignored", a4, 1'b1);
    cs_lo(); send(8'h66); send(8'h06); send(8'h99); cs_hi();
    check("R13 broken pair ignored", a4, 1'b1);
    rdsr(s); check("R13 status kept", s, 8'h1E);
    cs_lo(); send(8'h66); send(8'h99); cs_hi();
    check("R13 mode cleared", a4, 1'b0);
    rdsr(s); check("R13 status cleared", s, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule